// File: doc/BRIEF.md
# Video DRAM Cycle Decoder

This block sits in front of a dual-port video memory and turns its asynchronous, active-low strobe and control pins into clean, clock-synchronous cycle information. Each strobe and control pin passes through a two-stage synchroniser. The block sees a falling or rising strobe edge as a change between two consecutive synchronised samples. It then records what kind of cycle the memory controller asked for, together with the addresses carried on the shared 9-bit address bus.

A cycle starts when the row strobe falls. At that moment the transfer-select, write-enable, serial-enable, column-strobe and special-function levels fix the cycle kind for the rest of the cycle. The kind is a plain random-access cycle, a masked write that takes its bit mask from the data port, or a transfer from a memory row into the serial register. A later column-strobe fall latches a column address for random-access kinds. For a transfer it loads the serial tap start position instead. The random data port output enable is produced for plain random-access cycles. The row strobe rising ends the cycle.

Top module: `vram_cycle_decoder`

## Requirements
- R1: The row address and the cycle context are latched from pin levels held when the row strobe fell. They appear on the outputs, together with a one-clock `row_evt` pulse, on the third rising clock edge after the row-strobe pin goes low (two synchroniser stages plus one register).
- R2: If the transfer select is high at the row-strobe fall, the cycle is random-access (`cyc_kind` 1, or 2 when masked). If it is low, the cycle is a transfer (`cyc_kind` 3). `cyc_kind` 0 means no cycle is open.
- R3: A random-access cycle with write enable low at the row-strobe fall is a masked write (`cyc_kind` 2). `wr_mask` then takes the data-port value captured at that fall. For every other kind, `wr_mask` is all ones.
- R4: A column-strobe fall in an open random-access or masked cycle latches `col_addr`, the special-function level (`sf_at_col`) and the inverted write-enable level (`col_write`). It also pulses `col_evt` for one clock.
- R5: A column-strobe fall in an open transfer cycle loads `tap_addr` from the address bus and pulses `tap_evt` for one clock. `col_addr`, `sf_at_col` and `col_write` stay unchanged.
- R6: While a cycle is open, the row address and cycle kind do not change. A row-strobe rise clears `cyc_valid` and returns `cyc_kind` to 0 one register stage later. The latched addresses keep their values.
- R7: `dq_oe` is high only in an open plain random-access cycle (`cyc_kind` 1) while both the synchronised column strobe and the transfer select are low.
- R8: A column-strobe fall while the row strobe is high changes no address output and raises no event pulse. It sets `proto_err`, which stays high until reset.
- R9: Under reset, all outputs are zero except `wr_mask`, which is all ones.
- R10: `row_evt`, `col_evt` and `tap_evt` are single-clock pulses, one per detected strobe edge.
- R11: At the row-strobe fall, the block records three further levels. `sf_at_row` is the special-function level. `serial_en_at_row` is the inverted serial-enable level. `cas_before_row` is set when the column strobe is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| trg_n | input | 1 | Transfer select / output enable, active low |
| we_n | input | 1 | Write enable, active low |
| se_n | input | 1 | Serial enable, active low |
| sf | input | 1 | Special-function pin |
| addr | input | 9 | Multiplexed row / column / tap address |
| dq_in | input | 4 | Random data port value (write mask source) |
| cyc_valid | output | 1 | A cycle is open |
| cyc_kind | output | 2 | 0 none, 1 random, 2 masked write, 3 transfer |
| row_addr | output | 9 | Latched row address |
| wr_mask | output | 4 | Write mask for masked writes, otherwise all ones |
| sf_at_row | output | 1 | Special-function level at row fall |
| serial_en_at_row | output | 1 | Serial enable was active at row fall |
| cas_before_row | output | 1 | Column strobe was already low at row fall |
| col_addr | output | 9 | Latched column address |
| sf_at_col | output | 1 | Special-function level at column fall |
| col_write | output | 1 | Write enable was active at column fall |
| tap_addr | output | 9 | Serial tap start position |
| row_evt | output | 1 | One-clock pulse: row latched |
| col_evt | output | 1 | One-clock pulse: column latched |
| tap_evt | output | 1 | One-clock pulse: tap latched |
| dq_oe | output | 1 | Random data port output enable |
| proto_err | output | 1 | Sticky: column strobe fell with row strobe high |

## Verification
The bench targets four corner cases:
- Pin levels that change between strobe edges. A decoder that sampled levels after the edge, instead of in the same synchronised sample, would record the wrong kind or mask.
- A column fall inside a transfer cycle. A design that routed it to the column latch would corrupt `col_addr` and miss `tap_evt`.
- A column fall with the row strobe high, and a column strobe already low at the row fall. A design that mishandled these would produce a spurious column event or lose the sticky error.
- Transfer select toggled during random and transfer cycles. A wrong `dq_oe` qualifier would drive the data port during a transfer or a masked write.

A long phase of fully random pin activity also mixes simultaneous strobe edges into the traffic.

// File: rtl/vdc_pkg.sv
package vdc_pkg;

    localparam int ADDR_W      = 9;
    localparam int DQ_W        = 4;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CK_IDLE   = 2'd0,
        CK_RANDOM = 2'd1,
        CK_MASKED = 2'd2,
        CK_XFER   = 2'd3
    } cyc_kind_e;

    typedef struct packed {
        logic              ras_n;
        logic              cas_n;
        logic              trg_n;
        logic              we_n;
        logic              se_n;
        logic              sf;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   dq;
    } pin_sample_t;

    localparam int PIN_W = $bits(pin_sample_t);

    typedef struct packed {
        logic              valid;
        cyc_kind_e         kind;
        logic [ADDR_W-1:0] row;
        logic [DQ_W-1:0]   wmask;
        logic              sf_row;
        logic              ser_en;
        logic              cas_early;
    } row_ctx_t;

    typedef struct packed {
        logic [ADDR_W-1:0] col;
        logic              sf_col;
        logic              wr;
    } col_ctx_t;

    typedef struct packed {
        logic row;
        logic col;
        logic tap;
    } evt_t;

    localparam row_ctx_t ROW_CTX_RESET = '{
        valid: 1'b0, kind: CK_IDLE, row: '0, wmask: '1,
        sf_row: 1'b0, ser_en: 1'b0, cas_early: 1'b0
    };

    function automatic pin_sample_t pins_idle();
        pin_sample_t p;
        p       = '0;
        p.ras_n = 1'b1;
        p.cas_n = 1'b1;
        p.trg_n = 1'b1;
        p.we_n  = 1'b1;
        p.se_n  = 1'b1;
        return p;
    endfunction

    function automatic cyc_kind_e classify(input logic trg_n, input logic we_n);
        if (!trg_n)
            return CK_XFER;
        else if (!we_n)
            return CK_MASKED;
        else
            return CK_RANDOM;
    endfunction

endpackage

// File: rtl/vdc_sync.sv
module vdc_sync #(
    parameter int               WIDTH     = 8,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RESET_VAL;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RESET_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/vdc_edge.sv
module vdc_edge
    import vdc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_sample_t cur,
    output logic        ras_fall,
    output logic        ras_rise,
    output logic        cas_fall
);

    logic prev_ras_n;
    logic prev_cas_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ras_n <= 1'b1;
            prev_cas_n <= 1'b1;
        end else begin
            prev_ras_n <= cur.ras_n;
            prev_cas_n <= cur.cas_n;
        end
    end

    assign ras_fall = prev_ras_n & ~cur.ras_n;
    assign ras_rise = ~prev_ras_n & cur.ras_n;
    assign cas_fall = prev_cas_n & ~cur.cas_n;

    // R10: an edge cannot be reported twice in a row
    p_fall_once_r10: assert property (@(posedge clk) disable iff (rst)
        ras_fall |=> !ras_fall);
    p_cas_once_r10: assert property (@(posedge clk) disable iff (rst)
        cas_fall |=> !cas_fall);

endmodule

// File: rtl/vdc_cycle.sv
module vdc_cycle
    import vdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_sample_t       cur,
    input  logic              ras_fall,
    input  logic              ras_rise,
    input  logic              cas_fall,
    output row_ctx_t          rctx,
    output col_ctx_t          cctx,
    output logic [ADDR_W-1:0] tap,
    output evt_t              evt,
    output logic              dq_oe,
    output logic              proto_err
);

    row_ctx_t          rctx_d;
    col_ctx_t          cctx_d;
    logic [ADDR_W-1:0] tap_d;
    evt_t              evt_d;
    logic              oe_d;
    logic              err_d;
    cyc_kind_e         kind_now;

    assign kind_now = classify(cur.trg_n, cur.we_n);

    always_comb begin
        rctx_d = rctx;
        cctx_d = cctx;
        tap_d  = tap;
        evt_d  = '0;
        err_d  = proto_err;

        // column strobe: judged against the cycle already open
        if (cas_fall) begin
            if (cur.ras_n) begin
                err_d = 1'b1;
            end else if (rctx.valid) begin
                if (rctx.kind == CK_XFER) begin
                    tap_d     = cur.addr;
                    evt_d.tap = 1'b1;
                end else begin
                    cctx_d.col    = cur.addr;
                    cctx_d.sf_col = cur.sf;
                    cctx_d.wr     = ~cur.we_n;
                    evt_d.col     = 1'b1;
                end
            end
        end

        // row strobe: opens or closes a cycle
        if (ras_fall) begin
            rctx_d.valid     = 1'b1;
            rctx_d.kind      = kind_now;
            rctx_d.row       = cur.addr;
            rctx_d.wmask     = (kind_now == CK_MASKED) ? cur.dq : '1;
            rctx_d.sf_row    = cur.sf;
            rctx_d.ser_en    = ~cur.se_n;
            rctx_d.cas_early = ~cur.cas_n;
            evt_d.row        = 1'b1;
        end else if (ras_rise) begin
            rctx_d.valid = 1'b0;
            rctx_d.kind  = CK_IDLE;
        end

        oe_d = rctx_d.valid && (rctx_d.kind == CK_RANDOM) && !cur.cas_n && !cur.trg_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rctx      <= ROW_CTX_RESET;
            cctx      <= '0;
            tap       <= '0;
            evt       <= '0;
            dq_oe     <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            rctx      <= rctx_d;
            cctx      <= cctx_d;
            tap       <= tap_d;
            evt       <= evt_d;
            dq_oe     <= oe_d;
            proto_err <= err_d;
        end
    end

    // R6: row context frozen while the cycle is open
    p_row_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rctx.valid && !evt.row) |-> ($stable(rctx.row) && $stable(rctx.kind)));
    // R6: row strobe rise closes the cycle
    p_rise_close_r6: assert property (@(posedge clk) disable iff (rst)
        ras_rise |=> !rctx.valid);
    // R5: tap loads only in transfer cycles and leave the column latch alone
    p_tap_xfer_r5: assert property (@(posedge clk) disable iff (rst)
        evt.tap |-> (rctx.valid && rctx.kind == CK_XFER && $stable(cctx)));
    // R4: column loads only in random-access kinds
    p_col_random_r4: assert property (@(posedge clk) disable iff (rst)
        evt.col |-> (rctx.valid && rctx.kind != CK_XFER));
    // R7: output enable only in plain random cycles
    p_oe_kind_r7: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (rctx.valid && rctx.kind == CK_RANDOM));
    // R8: error flag is sticky
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);
    // R3: mask is all ones outside masked writes
    p_mask_open_r3: assert property (@(posedge clk) disable iff (rst)
        (rctx.valid && rctx.kind != CK_MASKED) |-> (rctx.wmask == '1));
    // R10: pulses last one clock
    p_row_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        evt.row |=> !evt.row);

endmodule

// File: rtl/vram_cycle_decoder.sv
module vram_cycle_decoder
    import vdc_pkg::*;
#(
    parameter int ADDR_BITS = vdc_pkg::ADDR_W,
    parameter int DQ_BITS   = vdc_pkg::DQ_W,
    parameter int STAGES    = vdc_pkg::SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 trg_n,
    input  logic                 we_n,
    input  logic                 se_n,
    input  logic                 sf,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [DQ_BITS-1:0]   dq_in,
    output logic                 cyc_valid,
    output logic [1:0]           cyc_kind,
    output logic [ADDR_BITS-1:0] row_addr,
    output logic [DQ_BITS-1:0]   wr_mask,
    output logic                 sf_at_row,
    output logic                 serial_en_at_row,
    output logic                 cas_before_row,
    output logic [ADDR_BITS-1:0] col_addr,
    output logic                 sf_at_col,
    output logic                 col_write,
    output logic [ADDR_BITS-1:0] tap_addr,
    output logic                 row_evt,
    output logic                 col_evt,
    output logic                 tap_evt,
    output logic                 dq_oe,
    output logic                 proto_err
);

    pin_sample_t       raw;
    pin_sample_t       cur;
    logic [PIN_W-1:0]  cur_vec;
    logic              ras_fall;
    logic              ras_rise;
    logic              cas_fall;
    row_ctx_t          rctx;
    col_ctx_t          cctx;
    evt_t              evt;
    logic [ADDR_W-1:0] tap;

    always_comb begin
        raw       = '0;
        raw.ras_n = ras_n;
        raw.cas_n = cas_n;
        raw.trg_n = trg_n;
        raw.we_n  = we_n;
        raw.se_n  = se_n;
        raw.sf    = sf;
        raw.addr  = addr;
        raw.dq    = dq_in;
    end

    vdc_sync #(
        .WIDTH     (PIN_W),
        .STAGES    (STAGES),
        .RESET_VAL (pins_idle())
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (cur_vec)
    );

    assign cur = pin_sample_t'(cur_vec);

    vdc_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .cur      (cur),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall)
    );

    vdc_cycle u_cycle (
        .clk       (clk),
        .rst       (rst),
        .cur       (cur),
        .ras_fall  (ras_fall),
        .ras_rise  (ras_rise),
        .cas_fall  (cas_fall),
        .rctx      (rctx),
        .cctx      (cctx),
        .tap       (tap),
        .evt       (evt),
        .dq_oe     (dq_oe),
        .proto_err (proto_err)
    );

    assign cyc_valid        = rctx.valid;
    assign cyc_kind         = rctx.kind;
    assign row_addr         = rctx.row;
    assign wr_mask          = rctx.wmask;
    assign sf_at_row        = rctx.sf_row;
    assign serial_en_at_row = rctx.ser_en;
    assign cas_before_row   = rctx.cas_early;
    assign col_addr         = cctx.col;
    assign sf_at_col        = cctx.sf_col;
    assign col_write        = cctx.wr;
    assign tap_addr         = tap;
    assign row_evt          = evt.row;
    assign col_evt          = evt.col;
    assign tap_evt          = evt.tap;

    // R10: row and column events never coincide
    p_evt_excl_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({row_evt, col_evt, tap_evt}));

endmodule

// File: tb/vram_cycle_decoder_tb_top.sv
module vram_cycle_decoder_tb_top;
    import vdc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic       ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1, we_n = 1'b1, se_n = 1'b1, sf = 1'b0;
    logic [8:0] addr  = '0;
    logic [3:0] dq_in = '0;

    logic       cyc_valid, sf_at_row, serial_en_at_row, cas_before_row, sf_at_col, col_write;
    logic [1:0] cyc_kind;
    logic [8:0] row_addr, col_addr, tap_addr;
    logic [3:0] wr_mask;
    logic       row_evt, col_evt, tap_evt, dq_oe, proto_err;

    vram_cycle_decoder dut_i (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n), .we_n(we_n),
        .se_n(se_n), .sf(sf), .addr(addr), .dq_in(dq_in),
        .cyc_valid(cyc_valid), .cyc_kind(cyc_kind), .row_addr(row_addr), .wr_mask(wr_mask),
        .sf_at_row(sf_at_row), .serial_en_at_row(serial_en_at_row),
        .cas_before_row(cas_before_row), .col_addr(col_addr), .sf_at_col(sf_at_col),
        .col_write(col_write), .tap_addr(tap_addr), .row_evt(row_evt), .col_evt(col_evt),
        .tap_evt(tap_evt), .dq_oe(dq_oe), .proto_err(proto_err)
    );

    int n_vec = 0;
    int n_bad = 0;

    // ---------------- behavioural reference ----------------
    pin_sample_t hist[$];
    logic       m_valid, m_sfr, m_ser, m_cbr, m_sfc, m_wr, m_re, m_ce, m_te, m_oe, m_err;
    logic [1:0] m_kind;
    logic [8:0] m_row, m_col, m_tap;
    logic [3:0] m_mask;

    task automatic model_reset();
        m_valid = 0; m_kind = 0; m_row = 0; m_mask = 4'hF; m_sfr = 0; m_ser = 0; m_cbr = 0;
        m_col = 0; m_sfc = 0; m_wr = 0; m_tap = 0; m_re = 0; m_ce = 0; m_te = 0;
        m_oe = 0; m_err = 0;
    endtask

    initial begin
        model_reset();
        for (int i = 0; i < 4; i++) hist.push_back(pins_idle());
    end

    always @(posedge clk) begin
        pin_sample_t now, c, p;
        logic was_valid;
        if (rst) begin
            model_reset();
            hist.push_back(pins_idle());
        end else begin
            now = '0;
            now.ras_n = ras_n; now.cas_n = cas_n; now.trg_n = trg_n; now.we_n = we_n;
            now.se_n = se_n; now.sf = sf; now.addr = addr; now.dq = dq_in;
            hist.push_back(now);
            c = hist[hist.size()-3];  // level seen two stages later
            p = hist[hist.size()-4];
            was_valid = m_valid;
            m_re = 0; m_ce = 0; m_te = 0;
            if (p.cas_n && !c.cas_n) begin
                if (c.ras_n) m_err = 1;
                else if (was_valid) begin
                    if (m_kind == 2'd3) begin m_tap = c.addr; m_te = 1; end
                    else begin m_col = c.addr; m_sfc = c.sf; m_wr = !c.we_n; m_ce = 1; end
                end
            end
            if (p.ras_n && !c.ras_n) begin
                m_valid = 1;
                m_kind  = !c.trg_n ? 2'd3 : (!c.we_n ? 2'd2 : 2'd1);
                m_row   = c.addr;
                m_mask  = (m_kind == 2'd2) ? c.dq : 4'hF;
                m_sfr = c.sf; m_ser = !c.se_n; m_cbr = !c.cas_n; m_re = 1;
            end else if (!p.ras_n && c.ras_n) begin
                m_valid = 0; m_kind = 0;
            end
            m_oe = m_valid && m_kind == 2'd1 && !c.cas_n && !c.trg_n;
        end
        if (hist.size() > 8) void'(hist.pop_front());
    end

    task automatic chk(input string what, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    bit compare_on = 0;
    always @(negedge clk) begin
        if (compare_on && !rst) begin
            chk("row_addr", "R1", 16'(row_addr), 16'(m_row));
            chk("row_evt", "R10", 16'(row_evt), 16'(m_re));
            chk("cyc_kind", "R2", 16'(cyc_kind), 16'(m_kind));
            chk("wr_mask", "R3", 16'(wr_mask), 16'(m_mask));
            chk("col", "R4", {6'd0, col_addr, sf_at_col}, {6'd0, m_col, m_sfc});
            chk("col_write/col_evt", "R4", {col_write, col_evt}, {m_wr, m_ce});
            chk("tap", "R5", {tap_evt, tap_addr}, {m_te, m_tap});
            chk("cyc_valid", "R6", 16'(cyc_valid), 16'(m_valid));
            chk("dq_oe", "R7", 16'(dq_oe), 16'(m_oe));
            chk("proto_err", "R8", 16'(proto_err), 16'(m_err));
            chk("row side levels", "R11", {sf_at_row, serial_en_at_row, cas_before_row},
                {m_sfr, m_ser, m_cbr});
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_row(input logic t, input logic w, input logic [8:0] r,
                            input logic [3:0] d, input logic s, input logic se);
        @(negedge clk);
        addr = r; trg_n = t; we_n = w; dq_in = d; sf = s; se_n = se;
        @(negedge clk);
        ras_n = 1'b0;
        wait_n(4);
    endtask

    task automatic col_strobe(input logic [8:0] c, input logic w, input logic s);
        @(negedge clk);
        addr = c; we_n = w; sf = s;
        @(negedge clk);
        cas_n = 1'b0;
        wait_n(4);
    endtask

    task automatic close_row();
        @(negedge clk);
        cas_n = 1'b1; ras_n = 1'b1; trg_n = 1'b1; we_n = 1'b1; se_n = 1'b1;
        wait_n(5);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_n(2);
        // R9: reset values while reset is held
        chk("reset valid/kind", "R9", {cyc_valid, cyc_kind}, 16'd0);
        chk("reset mask", "R9", 16'(wr_mask), 16'hF);
        chk("reset addrs", "R9", {row_addr, col_addr, tap_addr} != 0, 16'd0);
        chk("reset flags", "R9", {row_evt, col_evt, tap_evt, dq_oe, proto_err}, 16'd0);
        wait_n(3);
        @(negedge clk);
        rst = 1'b0;
        compare_on = 1;

        // R1 latency: row appears exactly on the third edge
        @(negedge clk);
        addr = 9'h0C3;
        @(negedge clk);
        ras_n = 1'b0;
        wait_n(2);
        chk("row not yet", "R1", 16'(row_evt), 16'd0);
        @(negedge clk);
        chk("row_evt at third edge", "R1", {row_evt, 6'd0, row_addr}, {1'b1, 6'd0, 9'h0C3});
        col_strobe(9'h155, 1'b0, 1'b1);
        chk("early write column", "R4", {col_write, sf_at_col, col_addr}, {1'b1, 1'b1, 9'h155});
        @(negedge clk); trg_n = 1'b0;
        wait_n(3);
        chk("oe in read", "R7", 16'(dq_oe), 16'd1);
        close_row();
        chk("closed", "R6", {cyc_valid, cyc_kind}, 16'd0);

        // R3 masked write
        open_row(1'b1, 1'b0, 9'h1F0, 4'hA, 1'b1, 1'b0);
        chk("masked kind/mask", "R3", {cyc_kind, wr_mask}, {2'd2, 4'hA});
        chk("row levels", "R11", {sf_at_row, serial_en_at_row}, 16'b11);
        col_strobe(9'h021, 1'b1, 1'b0);
        @(negedge clk); trg_n = 1'b0;
        wait_n(3);
        chk("no oe in masked", "R7", 16'(dq_oe), 16'd0);
        close_row();

        // R5 transfer with tap load
        open_row(1'b0, 1'b1, 9'h077, 4'h3, 1'b0, 1'b1);
        chk("xfer kind", "R2", 16'(cyc_kind), 16'd3);
        chk("xfer mask ones", "R3", 16'(wr_mask), 16'hF);
        col_strobe(9'h1A5, 1'b1, 1'b0);
        chk("tap loaded", "R5", 16'(tap_addr), 16'h1A5);
        chk("col kept", "R5", 16'(col_addr), 16'h021);
        chk("no oe in xfer", "R7", 16'(dq_oe), 16'd0);
        close_row();

        // R8 column fall with row high
        col_strobe(9'h0EE, 1'b1, 1'b1);
        chk("ignored col", "R8", {col_evt, col_addr}, {1'b0, 9'h021});
        chk("err set", "R8", 16'(proto_err), 16'd1);
        close_row();
        chk("err sticky", "R8", 16'(proto_err), 16'd1);

        // R11 column already low at row fall
        @(negedge clk); cas_n = 1'b0;
        wait_n(3);
        open_row(1'b1, 1'b1, 9'h101, 4'h0, 1'b0, 1'b1);
        chk("cas before row", "R11", 16'(cas_before_row), 16'd1);
        close_row();

        // structured random cycles
        for (int i = 0; i < 300; i++) begin
            open_row($urandom_range(0, 1), $urandom_range(0, 1), 9'($urandom),
                     4'($urandom), $urandom_range(0, 1), $urandom_range(0, 1));
            if ($urandom_range(0, 3) != 0)
                col_strobe(9'($urandom), $urandom_range(0, 1), $urandom_range(0, 1));
            @(negedge clk); trg_n = $urandom_range(0, 1);
            wait_n($urandom_range(1, 4));
            close_row();
        end

        // unconstrained pin activity, strobes may move together
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            ras_n = $urandom_range(0, 1); cas_n = $urandom_range(0, 1);
            trg_n = $urandom_range(0, 1); we_n = $urandom_range(0, 1);
            se_n = $urandom_range(0, 1);  sf = $urandom_range(0, 1);
            addr = 9'($urandom); dq_in = 4'($urandom);
        end
        close_row();
        wait_n(4);
        finish_run();
    end

endmodule